// File: doc/BRIEF.md
# Halfword SIMD Register Load/Store Unit

This unit carries out four halfword memory instructions that move 16-bit values between a file of sixteen 32-bit SIMD registers and a byte-addressed data memory. It decodes the instruction word and reads the base general register and the SIMD register through combinational read ports in the cycle the instruction is accepted. It forms the effective address as the base plus a signed offset that counts halfwords. It then runs one halfword transfer on a request/ready memory port.

On a load the fetched halfword is merged into one lane of the destination register, sign-extended, or copied to both lanes. On a store one lane of the source register is written to memory. Two of the opcodes also write the effective address back into the base register. That write is committed in the first cycle of the transfer, even while memory stalls. Only one instruction is in flight at a time, and a single-cycle done pulse marks its completion.

Top module: `hsimd_ldst`

## Requirements
- R1: The operation code sits in instruction bits [5:0]: 0x2A is a load, 0x2B a store, 0x2C a load with base post-modify and 0x2D a store with base post-modify. Any other code is consumed with no memory request and no register write. Bits [31:26] are not decoded.
- R2: The effective address on `mem_addr_o` is the base register value plus the 9-bit two's-complement offset in bits [18:10] times two. The SIMD register index is bits [9:6], the lane option is bits [20:19] and the base register index is bits [25:21].
- R3: For 0x2C and 0x2D the effective address is written to the base register exactly once, in the first cycle of the transfer, before the transfer completes even when memory stalls. The other opcodes never write the base register.
- R4: Byte enables are 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. Store data is placed in both 16-bit halves of `mem_wdata_o`. A load takes bits [15:0] or [31:16] of `mem_rdata_i` according to address bit 1.
- R5: Load option 0 replaces bits [15:0] of the SIMD register and keeps bits [31:16]. Option 1 replaces bits [31:16] and keeps bits [15:0].
- R6: Load option 2 writes the halfword sign-extended to 32 bits. Option 3 writes the halfword to both halves.
- R7: Store option 0 writes register bits [15:0] to memory. Store option 1 writes bits [31:16]. The SIMD register is not changed by a store.
- R8: A store with option 2 or 3, and any unknown code, makes no memory request and no register write. Its done pulse comes in the cycle after acceptance.
- R9: `ready_o` is low from acceptance until the done pulse. The request, address and direction stay stable while `mem_ready_i` is low. `done_o` is high for one cycle, in the handshake cycle, so a transfer with N wait cycles takes N+1 cycles after acceptance.
- R10: A load accepted right after a load to the same SIMD register merges into the value written by the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word is valid |
| instr_i | input | 32 | Instruction word |
| ready_o | output | 1 | Unit can accept an instruction |
| done_o | output | 1 | Instruction completes this cycle |
| gpr_raddr_o | output | 5 | Base register read index |
| gpr_rdata_i | input | XLEN | Base register read data |
| gpr_we_o | output | 1 | Base register write enable |
| gpr_waddr_o | output | 5 | Base register write index |
| gpr_wdata_o | output | XLEN | Base register write data |
| xr_raddr_o | output | 4 | SIMD register read index |
| xr_rdata_i | input | 32 | SIMD register read data |
| xr_we_o | output | 1 | SIMD register write enable |
| xr_waddr_o | output | 4 | SIMD register write index |
| xr_wdata_o | output | 32 | SIMD register write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | XLEN | Byte address |
| mem_be_o | output | 4 | Byte enables |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid in the handshake cycle |
| mem_ready_i | input | 1 | Memory accepts or completes the request |

## Verification
The assertions assume that memory raises `mem_ready_i` only while a request is pending. They also assume that both register files read combinationally and write on the clock edge. The bench models both files and a small word memory whose wait count it sets per instruction, and it raises ready only during a request. Base values are kept even so that every effective address is halfword aligned, and addresses are kept in a window that the memory model covers.

// File: rtl/hsimd_pkg.sv
package hsimd_pkg;
  localparam int OP_W   = 6;
  localparam int XR_IW  = 4;
  localparam int GPR_IW = 5;
  localparam int OFF_W  = 9;

  typedef enum logic [OP_W-1:0] {
    OP_LD   = 6'h2A,
    OP_ST   = 6'h2B,
    OP_LDPM = 6'h2C,
    OP_STPM = 6'h2D
  } op_e;

  typedef enum logic [1:0] {
    LANE_LO  = 2'd0,
    LANE_HI  = 2'd1,
    LANE_SX  = 2'd2,
    LANE_DUP = 2'd3
  } lane_opt_e;

  typedef struct packed {
    logic              is_load;
    logic              postmod;
    logic              nop;
    lane_opt_e         opt;
    logic [XR_IW-1:0]  xr;
    logic [GPR_IW-1:0] rb;
    logic [OFF_W-1:0]  off;
  } dec_t;
endpackage

// File: rtl/hsimd_decode.sv
module hsimd_decode
  import hsimd_pkg::*;
(
  input  logic [31:0] instr_i,
  output dec_t        dec_o
);
  logic [OP_W-1:0] op;
  logic            known;
  logic            unused_major;

  assign op           = instr_i[OP_W-1:0];
  assign unused_major = ^instr_i[31:26];

  always_comb begin
    known         = 1'b1;
    dec_o.is_load = 1'b0;
    dec_o.postmod = 1'b0;
    unique case (op)
      OP_LD:   dec_o.is_load = 1'b1;
      OP_ST:   ;
      OP_LDPM: begin dec_o.is_load = 1'b1; dec_o.postmod = 1'b1; end
      OP_STPM: dec_o.postmod = 1'b1;
      default: known = 1'b0;
    endcase
    dec_o.opt = lane_opt_e'(instr_i[20:19]);
    dec_o.xr  = instr_i[9:6];
    dec_o.rb  = instr_i[25:21];
    dec_o.off = instr_i[18:10];
    // reserved store lane options behave like an unknown code
    dec_o.nop = !known || (!dec_o.is_load && instr_i[20]);
  end
endmodule

// File: rtl/hsimd_agen.sv
module hsimd_agen
  import hsimd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]  base_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [XLEN-1:0]  ea_o
);
  localparam int EXT_W = XLEN - OFF_W - 1;

  assign ea_o = base_i + {{EXT_W{off_i[OFF_W-1]}}, off_i, 1'b0};
endmodule

// File: rtl/hsimd_lane.sv
module hsimd_lane
  import hsimd_pkg::*;
#(
  parameter int DW = 32
) (
  input  lane_opt_e       opt_i,
  input  logic            addr_hi_i,
  input  logic [DW-1:0]   rdata_i,
  input  logic [DW-1:0]   old_i,
  input  logic [DW-1:0]   src_i,
  output logic [DW-1:0]   load_o,
  output logic [DW-1:0]   wdata_o,
  output logic [DW/8-1:0] be_o
);
  localparam int HW  = DW / 2;
  localparam int HBE = DW / 16;

  logic [HW-1:0] ld_h, st_h;

  assign ld_h = addr_hi_i ? rdata_i[DW-1:HW] : rdata_i[HW-1:0];
  assign st_h = opt_i[0] ? src_i[DW-1:HW] : src_i[HW-1:0];
  assign wdata_o = {st_h, st_h};

  for (genvar g = 0; g < 2; g++) begin : g_be
    assign be_o[g*HBE +: HBE] = {HBE{addr_hi_i == g[0]}};
  end

  always_comb begin
    unique case (opt_i)
      LANE_LO:  load_o = {old_i[DW-1:HW], ld_h};
      LANE_HI:  load_o = {ld_h, old_i[HW-1:0]};
      LANE_SX:  load_o = {{HW{ld_h[HW-1]}}, ld_h};
      default:  load_o = {ld_h, ld_h};
    endcase
  end
endmodule

// File: rtl/hsimd_ctrl.sv
module hsimd_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic nop_i,
  input  logic postmod_i,
  input  logic mem_ready_i,
  output logic ready_o,
  output logic mem_req_o,
  output logic gpr_we_o,
  output logic done_o
);
  logic busy_q, nop_q, pm_q, first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      nop_q   <= 1'b0;
      pm_q    <= 1'b0;
      first_q <= 1'b0;
    end else if (accept_i) begin
      busy_q  <= 1'b1;
      nop_q   <= nop_i;
      pm_q    <= postmod_i && !nop_i;
      first_q <= 1'b1;
    end else if (busy_q) begin
      first_q <= 1'b0;
      if (done_o) busy_q <= 1'b0;
    end
  end

  assign ready_o   = !busy_q;
  assign mem_req_o = busy_q && !nop_q;
  // base writeback in the first transfer cycle, independent of stalls
  assign gpr_we_o  = mem_req_o && first_q && pm_q;
  assign done_o    = busy_q && (nop_q || mem_ready_i);
endmodule

// File: rtl/hsimd_ldst.sv
module hsimd_ldst
  import hsimd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               instr_valid_i,
  input  logic [31:0]        instr_i,
  output logic               ready_o,
  output logic               done_o,
  output logic [GPR_IW-1:0]  gpr_raddr_o,
  input  logic [XLEN-1:0]    gpr_rdata_i,
  output logic               gpr_we_o,
  output logic [GPR_IW-1:0]  gpr_waddr_o,
  output logic [XLEN-1:0]    gpr_wdata_o,
  output logic [XR_IW-1:0]   xr_raddr_o,
  input  logic [31:0]        xr_rdata_i,
  output logic               xr_we_o,
  output logic [XR_IW-1:0]   xr_waddr_o,
  output logic [31:0]        xr_wdata_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [XLEN-1:0]    mem_addr_o,
  output logic [3:0]         mem_be_o,
  output logic [31:0]        mem_wdata_o,
  input  logic [31:0]        mem_rdata_i,
  input  logic               mem_ready_i
);
  localparam int DW = 32;

  dec_t            dec, dec_q;
  logic [XLEN-1:0] ea, ea_q;
  logic [DW-1:0]   old_q, load_val;
  logic            accept;

  hsimd_decode u_dec (.instr_i(instr_i), .dec_o(dec));

  hsimd_agen #(.XLEN(XLEN)) u_agen (
    .base_i(gpr_rdata_i), .off_i(dec.off), .ea_o(ea)
  );

  assign accept      = instr_valid_i && ready_o;
  assign gpr_raddr_o = dec.rb;
  assign xr_raddr_o  = dec.xr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q <= '0;
      ea_q  <= '0;
      old_q <= '0;
    end else if (accept) begin
      dec_q <= dec;
      ea_q  <= ea;
      old_q <= xr_rdata_i;
    end
  end

  hsimd_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept),
    .nop_i(dec.nop), .postmod_i(dec.postmod), .mem_ready_i(mem_ready_i),
    .ready_o(ready_o), .mem_req_o(mem_req_o), .gpr_we_o(gpr_we_o),
    .done_o(done_o)
  );

  hsimd_lane #(.DW(DW)) u_lane (
    .opt_i(dec_q.opt), .addr_hi_i(ea_q[1]), .rdata_i(mem_rdata_i),
    .old_i(old_q), .src_i(old_q), .load_o(load_val),
    .wdata_o(mem_wdata_o), .be_o(mem_be_o)
  );

  assign mem_addr_o  = ea_q;
  assign mem_we_o    = mem_req_o && !dec_q.is_load;
  assign gpr_waddr_o = dec_q.rb;
  assign gpr_wdata_o = ea_q;
  assign xr_we_o     = done_o && mem_req_o && dec_q.is_load;
  assign xr_waddr_o  = dec_q.xr;
  assign xr_wdata_o  = load_val;
endmodule

// File: rtl/hsimd_ldst_chk.sv
module hsimd_ldst_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            instr_valid_i,
  input logic            ready_o,
  input logic            done_o,
  input logic            gpr_we_o,
  input logic [XLEN-1:0] gpr_wdata_o,
  input logic            xr_we_o,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic [XLEN-1:0] mem_addr_o,
  input logic [3:0]      mem_be_o,
  input logic            mem_ready_i
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && ready_o |=> !ready_o); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mem_req_o && !done_o); // R9
  AST_BE_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_be_o == (mem_addr_o[1] ? 4'b1100 : 4'b0011))); // R4
  AST_BASE_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpr_we_o |-> mem_req_o && gpr_wdata_o == mem_addr_o); // R3
  AST_BASE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpr_we_o |=> !gpr_we_o); // R3
  AST_LOAD_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xr_we_o |-> done_o && mem_req_o && !mem_we_o); // R5
  AST_NOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !mem_req_o |-> !xr_we_o && !gpr_we_o); // R8
endmodule

bind hsimd_ldst hsimd_ldst_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/hsimd_ldst_test.sv
module hsimd_ldst_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic        ready, done;
  logic [4:0]  gpr_raddr, gpr_waddr;
  logic [31:0] gpr_rdata, gpr_wdata;
  logic        gpr_we;
  logic [3:0]  xr_raddr, xr_waddr;
  logic [31:0] xr_rdata, xr_wdata;
  logic        xr_we;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  logic [31:0] gpr [32];
  logic [31:0] xr  [16];
  logic [31:0] mem [64];
  logic [3:0]  wcnt;
  logic [3:0]  lat_r = '0;
  logic [1:0]  pk_kind = '0;
  logic [5:0]  pk_a = '0;
  logic [31:0] pk_d = '0;
  int          hs_cnt = 0;
  int          checks = 0;
  int          fails = 0;

  always #5 clk = ~clk;

  hsimd_ldst uut (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(instr_valid), .instr_i(instr),
    .ready_o(ready), .done_o(done),
    .gpr_raddr_o(gpr_raddr), .gpr_rdata_i(gpr_rdata), .gpr_we_o(gpr_we),
    .gpr_waddr_o(gpr_waddr), .gpr_wdata_o(gpr_wdata),
    .xr_raddr_o(xr_raddr), .xr_rdata_i(xr_rdata), .xr_we_o(xr_we),
    .xr_waddr_o(xr_waddr), .xr_wdata_o(xr_wdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_be_o(mem_be), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_ready_i(mem_ready)
  );

  assign gpr_rdata = gpr[gpr_raddr];
  assign xr_rdata  = xr[xr_raddr];
  assign mem_rdata = mem[mem_addr[7:2]];
  assign mem_ready = mem_req && (wcnt >= lat_r);

  always @(posedge clk) begin
    wcnt <= (!mem_req || mem_ready) ? 4'd0 : wcnt + 4'd1;
    if (gpr_we) gpr[gpr_waddr] <= gpr_wdata;
    if (xr_we) xr[xr_waddr] <= xr_wdata;
    if (mem_req && mem_ready) begin
      hs_cnt <= hs_cnt + 1;
      if (mem_we)
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[7:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end
    case (pk_kind)
      2'd1: gpr[pk_a[4:0]] <= pk_d;
      2'd2: xr[pk_a[3:0]] <= pk_d;
      2'd3: mem[pk_a] <= pk_d;
      default: ;
    endcase
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [1:0] kind, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    pk_kind = kind; pk_a = a; pk_d = d;
    @(negedge clk);
    pk_kind = 2'd0;
  endtask

  function automatic logic [31:0] enc(input logic [5:0] op, input logic [3:0] x,
      input logic [8:0] off, input logic [1:0] opt, input logic [4:0] rb);
    return {6'b0, rb, opt, off, x, op};
  endfunction

  task automatic run(input logic [31:0] w, input logic [3:0] lat, output int cyc);
    @(negedge clk);
    lat_r = lat; instr = w; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    @(posedge clk);
  endtask

  typedef struct packed {
    logic [5:0]  op;
    logic [8:0]  off;
    logic [1:0]  opt;
    logic [31:0] base;
    logic [31:0] xr0;
    logic [31:0] mw;
    logic [3:0]  lat;
    logic        nop;
    logic [31:0] exp_xr;
    logic [31:0] exp_mw;
    logic [31:0] exp_base;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{6'h2A, 9'h002, 2'd0, 32'h40,  32'hAAAA5555, 32'hBEEF1234, 4'd0, 1'b0, 32'hAAAA1234, 32'hBEEF1234, 32'h40},  // R5 lo
    '{6'h2C, 9'h003, 2'd1, 32'h40,  32'h11112222, 32'h87654321, 4'd2, 1'b0, 32'h87652222, 32'h87654321, 32'h46},  // R5 hi
    '{6'h2A, 9'h1FE, 2'd2, 32'h40,  32'h00000000, 32'h00009ABC, 4'd1, 1'b0, 32'hFFFF9ABC, 32'h00009ABC, 32'h40},  // R6 sx neg
    '{6'h2C, 9'h1FF, 2'd2, 32'h40,  32'hFFFFFFFF, 32'h7F000000, 4'd0, 1'b0, 32'h00007F00, 32'h7F000000, 32'h3E},  // R6 sx pos
    '{6'h2A, 9'h000, 2'd3, 32'h40,  32'h12345678, 32'hFFFFC0DE, 4'd3, 1'b0, 32'hC0DEC0DE, 32'hFFFFC0DE, 32'h40},  // R6 dup
    '{6'h2B, 9'h001, 2'd0, 32'h40,  32'h13572468, 32'hDEADBEEF, 4'd1, 1'b0, 32'h13572468, 32'h2468BEEF, 32'h40},  // R7 lo
    '{6'h2D, 9'h004, 2'd1, 32'h40,  32'h13572468, 32'hDEADBEEF, 4'd0, 1'b0, 32'h13572468, 32'hDEAD1357, 32'h48},  // R7 hi
    '{6'h2D, 9'h100, 2'd1, 32'h240, 32'hCAFE0001, 32'h11112222, 4'd2, 1'b0, 32'hCAFE0001, 32'h1111CAFE, 32'h40},  // R2 min off
    '{6'h2C, 9'h0FF, 2'd0, 32'h0,   32'h5555FFFF, 32'hABCD0000, 4'd0, 1'b0, 32'h5555ABCD, 32'hABCD0000, 32'h1FE}, // R2 max off
    '{6'h2D, 9'h002, 2'd2, 32'h40,  32'h99998888, 32'h01020304, 4'd0, 1'b1, 32'h99998888, 32'h01020304, 32'h40},  // R8 opt2
    '{6'h2B, 9'h002, 2'd3, 32'h40,  32'h99998888, 32'h01020304, 4'd0, 1'b1, 32'h99998888, 32'h01020304, 32'h40},  // R8 opt3
    '{6'h2E, 9'h002, 2'd0, 32'h40,  32'h99998888, 32'h01020304, 4'd0, 1'b1, 32'h99998888, 32'h01020304, 32'h40}   // R1 unknown
  };

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cyc;
    int hs0;
    logic [31:0] ea;
    repeat (3) @(negedge clk);
    chk(ready && !done && !mem_req && !gpr_we && !xr_we, "R9 reset idle",
        {27'b0, ready, done, mem_req, gpr_we, xr_we}, 32'h10);
    rst_n = 1'b1;

    // R1..R8 vector table
    for (int i = 0; i < NV; i++) begin
      ea = VEC[i].base + {{22{VEC[i].off[8]}}, VEC[i].off, 1'b0};
      poke(2'd1, 6'd5, VEC[i].base);
      poke(2'd2, 6'd3, VEC[i].xr0);
      poke(2'd3, ea[7:2], VEC[i].mw);
      hs0 = hs_cnt;
      run(enc(VEC[i].op, 4'd3, VEC[i].off, VEC[i].opt, 5'd5), VEC[i].lat, cyc);
      @(negedge clk);
      chk(xr[3] == VEC[i].exp_xr, "R5/R6 simd reg", xr[3], VEC[i].exp_xr);
      chk(mem[ea[7:2]] == VEC[i].exp_mw, "R4/R7 mem word", mem[ea[7:2]], VEC[i].exp_mw);
      chk(gpr[5] == VEC[i].exp_base, "R2/R3 base reg", gpr[5], VEC[i].exp_base);
      chk(cyc == (VEC[i].nop ? 1 : int'(VEC[i].lat) + 1), "R9 latency", cyc,
          VEC[i].nop ? 1 : int'(VEC[i].lat) + 1);
      chk((hs_cnt - hs0) == (VEC[i].nop ? 0 : 1), "R8 request count", hs_cnt - hs0,
          VEC[i].nop ? 0 : 1);
    end

    // R3: base writeback lands while memory still stalls
    poke(2'd1, 6'd9, 32'h20);
    poke(2'd3, 6'd9, 32'h0000AAAA);
    @(negedge clk);
    lat_r = 4'd3; instr = enc(6'h2C, 4'd1, 9'h002, 2'd0, 5'd9); instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    chk(gpr_we && mem_req && !done, "R3 wb first cycle", {29'b0, gpr_we, mem_req, done}, 32'h6);
    @(negedge clk);
    chk(gpr[9] == 32'h24 && !done && !gpr_we, "R3 base before done", gpr[9], 32'h24);
    chk(!ready, "R9 busy while stalled", {31'b0, ready}, 32'h0);
    while (!done) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    chk(ready, "R9 ready after done", {31'b0, ready}, 32'h1);

    // R10: back-to-back loads into the same SIMD register
    poke(2'd1, 6'd2, 32'h80);
    poke(2'd2, 6'd7, 32'h0);
    poke(2'd3, 6'd32, 32'h44443333);
    run(enc(6'h2A, 4'd7, 9'h000, 2'd0, 5'd2), 4'd0, cyc);
    run(enc(6'h2A, 4'd7, 9'h001, 2'd1, 5'd2), 4'd1, cyc);
    @(negedge clk);
    chk(xr[7] == 32'h44443333, "R10 back-to-back merge", xr[7], 32'h44443333);

    // R4: store byte lanes with wait states leave the other half intact
    poke(2'd1, 6'd4, 32'h10);
    poke(2'd2, 6'd2, 32'hF00DBABE);
    poke(2'd3, 6'd4, 32'h00000000);
    run(enc(6'h2B, 4'd2, 9'h001, 2'd0, 5'd4), 4'd2, cyc);
    run(enc(6'h2B, 4'd2, 9'h000, 2'd1, 5'd4), 4'd0, cyc);
    @(negedge clk);
    chk(mem[4] == 32'hBABEF00D, "R4 both lanes", mem[4], 32'hBABEF00D);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule